// File: doc/BRIEF.md
# Serial-Loaded Latched Channel Driver

This block is the digital front end of a 20-channel display driver. A host sends a frame of channel bits on a serial clock/data pair. Every rising serial clock edge moves the data line into a shift register. A load strobe copies the register into an output latch. While the strobe is high the latch is transparent, so the channel outputs follow the register as bits arrive. When the strobe falls, the latch freezes the last frame shifted in, and it keeps that frame while the strobe stays low.

A blanking input drives every channel output low but leaves the latch unchanged. When blanking is released, the stored frame shows again. The bit that leaves the far end of the shift register is sent out on a serial output. Several drivers can therefore be chained in series. They can also sit in parallel on one clock/data pair, each with its own load strobe.

The serial clock, the data line and the load strobe are all sampled in the system clock domain. Their edges are found by comparing each registered sample with the sample taken one cycle earlier.

Top module: `sld_serial_driver`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register and the latch. After reset, `ser_out` is 0 and all `chan_out` bits are 0.
- R2: Each rising edge of `ser_clk` shifts the register by one place. Bit 0 takes `ser_data`, and each bit i takes the old bit i-1. `ser_out` is always register bit 19.
- R3: A frame sends the most significant bit first. After exactly 20 shifts, the first bit sent sits in bit 19 and drives `chan_out[19]`, and the last bit sent drives `chan_out[0]`.
- R4: The register shifts on every rising `ser_clk` edge, whatever the level of `load_in`.
- R5: While `load_in` is high, `chan_out` follows the shift register contents as they change.
- R6: After `load_in` falls, `chan_out` holds the captured frame while `load_in` stays low, even if shifting continues.
- R7: While `blank_in` is high, all `chan_out` bits are 0. Blanking does not alter the latch, so the frame returns when `blank_in` goes low.
- R8: During a following frame, the bits of the previous frame leave on `ser_out` in their original order, with the first bit sent leaving first. This is the cascading behaviour.
- R9: A `ser_clk` held high or low, and a falling `ser_clk` edge, do not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_data | input | 1 | Serial data in |
| load_in | input | 1 | Load strobe; transparent while high, holds from its falling edge |
| blank_in | input | 1 | Forces all channel outputs low |
| ser_out | output | 1 | Last register stage, for cascading |
| chan_out | output | 20 | Channel outputs |

## Verification
A rising `ser_clk` edge reaches the register and `ser_out` on the second system clock edge after it is driven. It reaches a transparent latch on the third edge. A change of `load_in` acts on the latch on the second edge, and `blank_in` acts on `chan_out` within the same cycle. The bench drives each input on a falling system clock edge. It samples the outputs three falling edges later, which is the first point at which every delayed result has landed. A check is made only there, never earlier.

// File: rtl/sld_pkg.sv
package sld_pkg;

    localparam int DEF_CHANNELS = 20;

    // Sampled view of one slow control input.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t make_edge(logic now_v, logic prev_v);
        edge_t e;
        e.level = now_v;
        e.rise  = now_v & ~prev_v;
        e.fall  = ~now_v & prev_v;
        return e;
    endfunction

endpackage

// File: rtl/sld_edge_detect.sv
module sld_edge_detect
    import sld_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t ev
);
    logic cur_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= pin;
            prev_q <= cur_q;
        end
    end

    always_comb ev = make_edge(cur_q, prev_q);

    // Two rising edges cannot occur in back-to-back cycles (R2 edge qualifier)
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> !ev.rise);

endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain
    import sld_pkg::*;
#(
    parameter int WIDTH = DEF_CHANNELS
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_t            sclk_ev,
    input  logic             din,
    output logic [WIDTH-1:0] bits
);
    localparam int TOP = WIDTH - 1;

    always_ff @(posedge clk) begin
        if (rst)
            bits <= '0;
        else if (sclk_ev.rise)
            bits <= {bits[TOP-1:0], din};
    end

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
        sclk_ev.rise |=> bits == {$past(bits[TOP-1:0]), $past(din)});

    assert_no_shift_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        sclk_ev.fall |=> $stable(bits));

    assert_no_shift_when_low_R9: assert property (@(posedge clk) disable iff (rst)
        !sclk_ev.level |=> $stable(bits));

endmodule

// File: rtl/sld_hold_latch.sv
module sld_hold_latch
    import sld_pkg::*;
#(
    parameter int WIDTH = DEF_CHANNELS
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_t            ld_ev,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic take;

    // Transparent while the strobe is high; one final capture on its fall.
    always_comb take = ld_ev.level | ld_ev.fall;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (take)
            q <= d;
    end

    assert_follow_while_high_R5: assert property (@(posedge clk) disable iff (rst)
        ld_ev.level |=> q == $past(d));

    assert_hold_while_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld_ev.level && !ld_ev.fall) |=> $stable(q));

    assert_capture_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        ld_ev.rise |=> q == $past(d));

endmodule

// File: rtl/sld_serial_driver.sv
module sld_serial_driver
    import sld_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                load_in,
    input  logic                blank_in,
    output logic                ser_out,
    output logic [CHANNELS-1:0] chan_out
);
    localparam int MSB = CHANNELS - 1;

    edge_t               sclk_ev;
    edge_t               ld_ev;
    logic                din_q;
    logic [CHANNELS-1:0] shreg;
    logic [CHANNELS-1:0] latch_q;

    // Data is sampled alongside the serial clock so both share one delay.
    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b0;
        else     din_q <= ser_data;
    end

    sld_edge_detect u_sclk_edge (
        .clk (clk),
        .rst (rst),
        .pin (ser_clk),
        .ev  (sclk_ev)
    );

    sld_edge_detect u_load_edge (
        .clk (clk),
        .rst (rst),
        .pin (load_in),
        .ev  (ld_ev)
    );

    sld_shift_chain #(.WIDTH(CHANNELS)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_ev (sclk_ev),
        .din     (din_q),
        .bits    (shreg)
    );

    sld_hold_latch #(.WIDTH(CHANNELS)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .ld_ev (ld_ev),
        .d     (shreg),
        .q     (latch_q)
    );

    assign ser_out = shreg[MSB];

    // Per-channel blanking gate.
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_gate
        assign chan_out[ch] = latch_q[ch] & ~blank_in;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (latch_q == '0 && !ser_out));

endmodule

// File: tb/test_sld_serial_driver.sv
`timescale 1ns/1ps
module test_sld_serial_driver;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, load_in = 1'b0, blank_in = 1'b0;
    logic ser_out;
    logic [N-1:0] chan_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    logic [N-1:0] exp_sh = '0;
    logic [N-1:0] exp_lat = '0;

    always #10 clk = ~clk;

    sld_serial_driver #(.CHANNELS(N)) i_sld_serial_driver (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_in(load_in), .blank_in(blank_in),
        .ser_out(ser_out), .chan_out(chan_out)
    );

    function automatic logic [N-1:0] exp_chan();
        return blank_in ? '0 : exp_lat;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b1;
        repeat (3) @(negedge clk);
        exp_sh = {exp_sh[N-2:0], b};
        if (load_in) exp_lat = exp_sh;
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(logic [N-1:0] v, string req);
        for (int i = N - 1; i >= 0; i--) begin
            shift_bit(v[i]);
            check(req, {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, exp_sh[N-1]});
        end
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_in = 1'b1;
        repeat (3) @(negedge clk);
        exp_lat = exp_sh;
        load_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] frame_a, frame_b, held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 chan", chan_out, '0);
        check("R1 dout", {{(N-1){1'b0}}, ser_out}, '0);

        // R3 directed bit order: first bit lands on channel 19
        send_frame(20'h80001, "R2 shift");
        pulse_load();
        check("R3 order", chan_out, 20'h80001);
        send_frame(20'h00003, "R2 shift");
        pulse_load();
        check("R3 order", chan_out, 20'h00003);

        // Random frames; R8 cascading: old frame leaves on ser_out in order
        for (int k = 0; k < 6; k++) begin
            frame_a = N'($urandom);
            frame_b = N'($urandom);
            send_frame(frame_a, "R2 shift");
            pulse_load();
            check("R3 random", chan_out, frame_a);
            for (int i = N - 1; i >= 0; i--) begin
                check("R8 cascade", {{(N-1){1'b0}}, ser_out},
                      {{(N-1){1'b0}}, frame_a[i]});
                shift_bit(frame_b[i]);
            end
            // R6/R4: shifting with load low leaves outputs frozen
            check("R6 hold", chan_out, frame_a);
            pulse_load();
            check("R4 shifted under low load", chan_out, frame_b);
        end

        // R5 transparency while load is high
        @(negedge clk);
        load_in = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            shift_bit(1'($urandom));
            check("R5 follow", chan_out, exp_chan());
        end
        @(negedge clk);
        load_in = 1'b0;
        repeat (3) @(negedge clk);
        held = exp_lat;
        for (int i = 0; i < 5; i++) shift_bit(1'($urandom));
        check("R6 frozen", chan_out, held);

        // R7 blanking
        @(negedge clk);
        blank_in = 1'b1;
        #1 check("R7 blank", chan_out, '0);
        shift_bit(1'b1);
        check("R7 blank while shifting", chan_out, '0);
        @(negedge clk);
        blank_in = 1'b0;
        #1 check("R7 restore", chan_out, held);

        // R9: held serial clock levels do not shift
        pulse_load();
        held = exp_sh;
        @(negedge clk);
        ser_data = 1'b1;
        ser_clk  = 1'b1;
        repeat (3) @(negedge clk);
        exp_sh = {exp_sh[N-2:0], 1'b1};
        held = exp_sh;
        for (int i = 0; i < 10; i++) begin
            ser_data = ~ser_data;
            @(negedge clk);
        end
        ser_clk = 1'b0;
        for (int i = 0; i < 10; i++) begin
            ser_data = ~ser_data;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        pulse_load();
        check("R9 no extra shift", chan_out, held);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule